// File: doc/BRIEF.md
# Bit/Byte Serial Highway Port

This block is the line-side port of a node on a serial highway. It turns the incoming line traffic into whole bytes for the message logic behind it, and it turns one parallel byte from that logic back into line traffic. A static mode input picks one of two line formats. In bit-serial mode a single data line carries framed bytes. In byte-parallel mode eight data lines carry one byte per highway clock. In both modes a single highway clock paces the line, and the block takes its rising edge as the moment to sample and to advance.

In bit-serial mode the receiver looks for a start bit, collects eight data bits and then checks the stop bit. It accepts bytes only once a set number of correctly framed bytes in a row has established byte synchronization. The transmitter in this mode does not run on its own schedule. Each start bit the receiver detects launches one outgoing frame, so the output stays aligned to the incoming bytes. In byte-parallel mode every rising highway clock edge captures the input lines and presents a new output byte.

The port runs on a system clock that is much faster than the highway clock (the highway runs at up to 5 MHz). The highway clock and data enter as ordinary synchronous inputs.

Top module: `hsp_port`

## Requirements
- R1: In bit mode, with byte sync held, the data bits of a frame (start bit 0, eight data bits with the least significant bit first, stop bit 1) are assembled into rx_data. rx_strobe is high for exactly one system clock, in the cycle after the clock that sampled the stop bit.
- R2: In bit mode, after reset or after a loss of sync, the first LOCK_COUNT correctly framed bytes produce no rx_strobe, and sync_lost stays high until the last of them has been sampled. sync_lost is never low while rx_strobe is high from an unlocked state.
- R3: In bit mode, a stop bit sampled as 0 raises sync_lost from the next cycle, produces no strobe, and makes the receiver hunt for a new start bit. LOCK_COUNT good frames are needed again before the next strobe.
- R4: In bit mode, any number of idle 1 bits between frames is ignored. Only a 0 sampled while hunting begins a frame.
- R5: In bit mode, the start bit detected by the receiver launches a transmit frame. From the cycle after that sampling clock, tx_bit is 0. After each later highway clock edge it shows the next bit: the eight data bits with the least significant bit first, then a 1. tx_bit changes only in the cycle after a sampling clock.
- R6: When no frame is being sent, tx_bit rests at 1.
- R7: In byte mode, each rising highway clock edge copies rx_byte into rx_data and makes rx_strobe high for one cycle, in the cycle after that edge is sampled.
- R8: In byte mode, each rising highway clock edge loads the held transmit byte onto tx_byte, visible from the next cycle. Between edges tx_byte stays unchanged.
- R9: A cycle with tx_load high stores tx_data as the held transmit byte. The next launch (bit mode) or the next edge (byte mode) sends that value.
- R10: After reset: rx_strobe is 0, rx_data is 0, tx_bit is 1, tx_byte is 0, and sync_lost is 1 in bit mode.
- R11: In byte mode, sync_lost is 0 and tx_bit is 1. In bit mode, tx_byte is 0.
- R12: Only a rising edge of hw_clk counts as a highway clock. A hw_clk held high for many cycles yields a single event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_byte | input | 1 | 1 selects byte-parallel mode, 0 selects bit-serial mode; static outside reset |
| hw_clk | input | 1 | Highway clock; its rising edge is the sampling event |
| rx_bit | input | 1 | Serial input data line used in bit mode |
| rx_byte | input | DATA_W | Parallel input data lines used in byte mode |
| tx_load | input | 1 | Stores tx_data as the held transmit byte |
| tx_data | input | DATA_W | Byte to be transmitted |
| rx_data | output | DATA_W | Last received byte |
| rx_strobe | output | 1 | One-cycle pulse marking a new byte in rx_data |
| tx_bit | output | 1 | Serial output data line |
| tx_byte | output | DATA_W | Parallel output data lines |
| sync_lost | output | 1 | High in bit mode while byte sync is not held |

## Verification
Every cycle, the assertions check four rules. Strobes and output changes occur only after a cycle in which hw_clk was high. A byte-mode strobe carries exactly the lines sampled one cycle earlier. No bit-mode strobe appears while sync is missing. The byte-mode outputs keep their fixed values. The bench scenarios cover the behaviour that depends on history: how many good frames lock takes, relock after a bad stop bit, idle gaps, LSB-first order on both lines, and the use of a freshly loaded transmit byte. A reference model compares all outputs on every clock.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    typedef enum logic [1:0] {
        RX_HUNT = 2'd0,
        RX_DATA = 2'd1,
        RX_STOP = 2'd2
    } rx_phase_e;
endpackage

// File: rtl/hsp_tick_detect.sv
module hsp_tick_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_clk,
    output logic tick
);
    typedef struct packed {
        logic hw_prev;
    } tick_state_t;

    tick_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.hw_prev = hw_clk;
        tick         = hw_clk & ~st_q.hw_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hsp_rx_framer.sv
module hsp_rx_framer
    import hsp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int LOCK_COUNT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              din,
    output logic [DATA_W-1:0] byte_o,
    output logic              byte_done,
    output logic              start_seen,
    output logic              locked
);
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int LOCK_W = $clog2(LOCK_COUNT + 1);

    typedef struct packed {
        rx_phase_e         phase;
        logic [CNT_W-1:0]  bit_cnt;
        logic [DATA_W-1:0] shreg;
        logic [LOCK_W-1:0] good_cnt;
        logic              locked;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        byte_done  = 1'b0;
        start_seen = 1'b0;
        if (!en) begin
            st_d.phase    = RX_HUNT;
            st_d.bit_cnt  = '0;
            st_d.good_cnt = '0;
            st_d.locked   = 1'b0;
        end else if (tick) begin
            unique case (st_q.phase)
                RX_HUNT: begin
                    if (!din) begin
                        start_seen   = 1'b1;
                        st_d.phase   = RX_DATA;
                        st_d.bit_cnt = '0;
                    end
                end
                RX_DATA: begin
                    st_d.shreg = {din, st_q.shreg[DATA_W-1:1]};
                    if (st_q.bit_cnt == CNT_W'(DATA_W - 1)) begin
                        st_d.phase = RX_STOP;
                    end else begin
                        st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    st_d.phase = RX_HUNT;
                    if (din) begin
                        if (st_q.locked) begin
                            byte_done = 1'b1;
                        end else if (st_q.good_cnt == LOCK_W'(LOCK_COUNT - 1)) begin
                            st_d.locked   = 1'b1;
                            st_d.good_cnt = '0;
                        end else begin
                            st_d.good_cnt = st_q.good_cnt + 1'b1;
                        end
                    end else begin
                        st_d.locked   = 1'b0;
                        st_d.good_cnt = '0;
                    end
                end
                default: st_d.phase = RX_HUNT;
            endcase
        end
        byte_o = st_q.shreg;
        locked = st_q.locked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= RX_HUNT;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hsp_tx_serializer.sv
module hsp_tx_serializer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              launch,
    input  logic [DATA_W-1:0] byte_i,
    output logic              dout
);
    localparam int FRAME_W = DATA_W + 2;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.frame = '1;
        end else if (launch) begin
            st_d.frame = {1'b1, byte_i, 1'b0};
        end else if (tick) begin
            st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
        end
        dout = st_q.frame[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hsp_port.sv
module hsp_port #(
    parameter int DATA_W     = 8,
    parameter int LOCK_COUNT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_byte,
    input  logic              hw_clk,
    input  logic              rx_bit,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_strobe,
    output logic              tx_bit,
    output logic [DATA_W-1:0] tx_byte,
    output logic              sync_lost
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] rx_data;
        logic              rx_strobe;
        logic [DATA_W-1:0] tx_byte;
    } port_state_t;

    port_state_t st_d, st_q;

    logic              tick;
    logic              serial_en;
    logic [DATA_W-1:0] fr_byte;
    logic              fr_done;
    logic              fr_start;
    logic              fr_locked;
    logic              ser_out;

    assign serial_en = ~mode_byte;

    hsp_tick_detect u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_clk (hw_clk),
        .tick   (tick)
    );

    hsp_rx_framer #(
        .DATA_W     (DATA_W),
        .LOCK_COUNT (LOCK_COUNT)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (serial_en),
        .tick       (tick),
        .din        (rx_bit),
        .byte_o     (fr_byte),
        .byte_done  (fr_done),
        .start_seen (fr_start),
        .locked     (fr_locked)
    );

    hsp_tx_serializer #(
        .DATA_W (DATA_W)
    ) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (serial_en),
        .tick   (tick),
        .launch (fr_start),
        .byte_i (st_q.hold),
        .dout   (ser_out)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rx_strobe = 1'b0;
        if (tx_load) begin
            st_d.hold = tx_data;
        end
        if (mode_byte) begin
            if (tick) begin
                st_d.rx_data   = rx_byte;
                st_d.rx_strobe = 1'b1;
                st_d.tx_byte   = st_q.hold;
            end
        end else if (fr_done) begin
            st_d.rx_data   = fr_byte;
            st_d.rx_strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_data   = st_q.rx_data;
    assign rx_strobe = st_q.rx_strobe;
    assign tx_byte   = mode_byte ? st_q.tx_byte : '0;
    assign tx_bit    = ser_out;
    assign sync_lost = serial_en & ~fr_locked;
endmodule

// File: rtl/hsp_port_chk.sv
module hsp_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_byte,
    input logic              hw_clk,
    input logic [DATA_W-1:0] rx_byte,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_strobe,
    input logic              tx_bit,
    input logic [DATA_W-1:0] tx_byte,
    input logic              sync_lost
);
    assert_strobe_after_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> $past(hw_clk));

    assert_byte_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_byte && rx_strobe) |-> (rx_data == $past(rx_byte)));

    assert_no_strobe_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_byte && rx_strobe) |-> !sync_lost);

    assert_serial_moves_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_byte && !$stable(tx_bit)) |-> $past(hw_clk));

    assert_parallel_moves_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_byte && !$stable(tx_byte)) |-> $past(hw_clk));

    assert_byte_mode_levels_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_byte |-> (tx_bit && !sync_lost));
endmodule

bind hsp_port hsp_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_byte (mode_byte),
    .hw_clk    (hw_clk),
    .rx_byte   (rx_byte),
    .rx_data   (rx_data),
    .rx_strobe (rx_strobe),
    .tx_bit    (tx_bit),
    .tx_byte   (tx_byte),
    .sync_lost (sync_lost)
);

// File: tb/tb_hsp_port.sv
`timescale 1ns/1ps
module tb_hsp_port;
    localparam int LOCK = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_byte = 1'b0;
    logic       hw_clk = 1'b0;
    logic       rx_bit = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic       rx_strobe;
    logic       tx_bit;
    logic [7:0] tx_byte;
    logic       sync_lost;

    int total = 0;
    int bad = 0;
    int stb_count = 0;
    logic [9:0] tx_cap;

    always #2.5 clk = ~clk;

    hsp_port #(.DATA_W(8), .LOCK_COUNT(LOCK)) dut (
        .clk(clk), .rst_n(rst_n), .mode_byte(mode_byte), .hw_clk(hw_clk),
        .rx_bit(rx_bit), .rx_byte(rx_byte), .tx_load(tx_load), .tx_data(tx_data),
        .rx_data(rx_data), .rx_strobe(rx_strobe), .tx_bit(tx_bit),
        .tx_byte(tx_byte), .sync_lost(sync_lost)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic       m_hq;
    int         m_st, m_cnt, m_good;
    logic       m_lk;
    logic [7:0] m_sh, m_hold;
    logic       e_stb, e_tx_bit;
    logic [7:0] e_rx_data, e_tx_byte;
    bit         txq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hq = 0; m_st = 0; m_cnt = 0; m_good = 0; m_lk = 0; m_sh = 0; m_hold = 0;
            e_stb = 0; e_tx_bit = 1; e_rx_data = 0; e_tx_byte = 0;
            txq.delete();
        end else begin
            logic tk, launch;
            logic [7:0] old_hold;
            tk = hw_clk && !m_hq;
            m_hq = hw_clk;
            e_stb = 0;
            old_hold = m_hold;
            launch = 0;
            if (tx_load) m_hold = tx_data;
            if (mode_byte) begin
                if (tk) begin
                    e_rx_data = rx_byte;
                    e_stb = 1;
                    e_tx_byte = old_hold;
                end
            end else if (tk) begin
                if (m_st == 0) begin
                    if (!rx_bit) begin m_st = 1; m_cnt = 0; launch = 1; end
                end else if (m_st == 1) begin
                    m_sh[m_cnt] = rx_bit;
                    m_cnt++;
                    if (m_cnt == 8) m_st = 2;
                end else begin
                    m_st = 0;
                    if (rx_bit) begin
                        if (m_lk) begin e_stb = 1; e_rx_data = m_sh; end
                        else begin
                            m_good++;
                            if (m_good == LOCK) begin m_lk = 1; m_good = 0; end
                        end
                    end else begin
                        m_lk = 0; m_good = 0;
                    end
                end
                if (launch) begin
                    txq.delete();
                    txq.push_back(1'b0);
                    for (int i = 0; i < 8; i++) txq.push_back(old_hold[i]);
                    txq.push_back(1'b1);
                    e_tx_bit = txq.pop_front();
                end else if (txq.size() > 0) begin
                    e_tx_bit = txq.pop_front();
                end else begin
                    e_tx_bit = 1;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_strobe) stb_count++;
            chk(mode_byte ? "R7" : "R1", rx_strobe, e_stb);
            chk(mode_byte ? "R7" : "R1", rx_data, e_rx_data);
            chk("R5", tx_bit, e_tx_bit);
            chk("R8", tx_byte, mode_byte ? e_tx_byte : 8'h00);
            chk("R3", sync_lost, !mode_byte && !m_lk);
        end
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n = 0; mode_byte = m; hw_clk = 0; rx_bit = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // one highway clock period of 8 system clocks; returns tx_bit seen in the low phase
    task automatic hw_period(input logic b, input logic [7:0] by, output logic cap);
        rx_bit = b; rx_byte = by;
        repeat (2) @(negedge clk);
        hw_clk = 1;
        repeat (4) @(negedge clk);
        hw_clk = 0;
        repeat (2) @(negedge clk);
        cap = tx_bit;
    endtask

    task automatic send_frame(input logic [7:0] v, input logic stop);
        logic c;
        hw_period(1'b0, 8'h00, c); tx_cap[0] = c;
        for (int i = 0; i < 8; i++) begin
            hw_period(v[i], 8'h00, c); tx_cap[i+1] = c;
        end
        hw_period(stop, 8'h00, c); tx_cap[9] = c;
    endtask

    task automatic load_tx(input logic [7:0] v);
        @(negedge clk); tx_load = 1; tx_data = v;
        @(negedge clk); tx_load = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic c;
        int base;
        do_reset(1'b0);
        // R10 reset state
        chk("R10", rx_strobe, 0);
        chk("R10", rx_data, 0);
        chk("R10", tx_bit, 1);
        chk("R10", tx_byte, 0);
        chk("R10", sync_lost, 1);

        // R2: lock acquisition, no strobes
        load_tx(8'h5A);
        send_frame(8'hA5, 1'b1);
        send_frame(8'h3C, 1'b1);
        chk("R2", sync_lost, 1);
        send_frame(8'h0F, 1'b1);
        chk("R2", stb_count, 0);
        chk("R2", sync_lost, 0);
        // R6: idle line
        chk("R6", tx_bit, 1);

        // R1 received byte after lock, R9 held byte on the serial output
        load_tx(8'hC3);
        send_frame(8'h81, 1'b1);
        chk("R1", stb_count, 1);
        chk("R1", rx_data, 8'h81);
        chk("R9", tx_cap[8:1], 8'hC3);
        chk("R5", tx_cap[0], 0);
        chk("R5", tx_cap[9], 1);

        // R4: idle ones are ignored
        for (int i = 0; i < 5; i++) hw_period(1'b1, 8'h00, c);
        chk("R4", stb_count, 1);
        chk("R6", tx_bit, 1);
        send_frame(8'h7E, 1'b1);
        chk("R4", stb_count, 2);
        chk("R4", rx_data, 8'h7E);

        // R3: bad stop bit loses sync, relock needed
        send_frame(8'h55, 1'b0);
        chk("R3", sync_lost, 1);
        chk("R3", stb_count, 2);
        hw_period(1'b1, 8'h00, c);
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        chk("R3", stb_count, 2);
        send_frame(8'h33, 1'b1);
        chk("R3", sync_lost, 0);
        send_frame(8'h44, 1'b1);
        chk("R3", stb_count, 3);
        chk("R3", rx_data, 8'h44);
        chk("R11", tx_byte, 0);

        // byte mode
        do_reset(1'b1);
        chk("R11", sync_lost, 0);
        chk("R11", tx_bit, 1);
        base = stb_count;
        load_tx(8'h9D);
        hw_period(1'b1, 8'h6B, c);
        chk("R7", rx_data, 8'h6B);
        chk("R8", tx_byte, 8'h9D);
        hw_period(1'b1, 8'hF0, c);
        chk("R7", rx_data, 8'hF0);
        load_tx(8'h01);
        chk("R9", tx_byte, 8'h9D);
        hw_period(1'b1, 8'h0E, c);
        chk("R9", tx_byte, 8'h01);
        chk("R7", stb_count - base, 3);

        // R12: a long high phase counts once
        base = stb_count;
        rx_byte = 8'hAA;
        @(negedge clk); hw_clk = 1;
        repeat (20) @(negedge clk);
        hw_clk = 0;
        repeat (3) @(negedge clk);
        chk("R12", stb_count - base, 1);
        chk("R12", rx_data, 8'hAA);

        summary();
    end
endmodule